// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This block is the lookup and refill controller of a small direct-mapped read cache with one extra chance to hit. Each request is first compared against the line slot chosen by its index bits. If that slot does not hold the line, the controller probes a second slot, found by inverting the most significant index bit. The result is a hit rate close to a two-way cache, while the common hit still needs only one comparison.

A hit in the first slot is a fast hit and is answered on the next cycle. A hit in the second slot is a slow hit. It costs one cycle for the extra probe and one cycle to exchange the two lines, so that the next access to the same line is a fast hit. When both probes fail, the access is a true miss. The controller requests the line from the next level and writes the returned line into the first slot. The line that was there moves into the second slot.

Each response carries a status code so the processor side can tell the three outcomes apart. Writes, dirty lines and multi-beat refills are not handled.

Top module: `pa_lookup_top`

## Requirements
- R1: When a request is accepted and its first slot holds the line, `rspValid` is high in the next cycle, with `rspStatus` = 2'b01 and `rspData` equal to the stored line.
- R2: When the first slot misses, the second probe uses the request index with its most significant bit inverted. Example: with a 4-bit index, index 4'b0011 has partner 4'b1011, and index 4'b1101 has partner 4'b0101.
- R3: A hit in the second slot is answered two cycles later than a fast hit: `rspValid` is high in the third cycle after acceptance, with `rspStatus` = 2'b10 and `rspData` equal to the line.
- R4: After a slow hit, the two slots have exchanged their contents, so the next access to the same address is a fast hit.
- R5: On a true miss, `fillReq` rises in the second cycle after acceptance, one cycle later than a plain direct-mapped lookup would raise it. `fillReq` then stays high, with `fillAddr` equal to the request address, until `fillValid` is seen.
- R6: In the cycle after `fillValid`, `rspValid` is high with `rspStatus` = 2'b11 and `rspData` equal to `fillData`. The returned line is stored in the first slot of the request.
- R7: On a refill, a valid line that was held in the first slot moves to the partner slot. If the first slot was empty, the partner slot keeps its contents.
- R8: Each slot stores the address bits above the index together with the index's top bit. Two addresses that differ only in that bit never hit on each other's line.
- R9: `busy` is high while the second probe, the swap or a refill is in progress, and `reqValid` is ignored during that time. `busy` is low in any cycle where `rspValid` is high.
- R10: Reset empties every slot and drives `busy`, `rspValid` and `fillReq` low. An address that was cached before the reset misses after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Read request, taken when `busy` is low |
| reqAddr | input | ADDR_W | Line address of the request |
| busy | output | 1 | Controller cannot take a request |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | DATA_W | Line returned to the requester |
| rspStatus | output | 2 | 01 fast hit, 10 slow hit, 11 miss, 00 idle |
| fillReq | output | 1 | Line request toward the next level |
| fillAddr | output | ADDR_W | Line address being refilled |
| fillValid | input | 1 | Next level returns the line this cycle |
| fillData | input | DATA_W | Line returned by the next level |

## Verification
The bench builds the block with ADDR_W = 8, IDX_W = 4 and DATA_W = 16, giving sixteen slots. With only sixteen slots, a few addresses are enough to drive one pair of partner slots through every transition: refill into an empty pair, displacement, swap back and forth, and eviction of the partner line. Addresses such as 8'h13 and 8'h1B differ only in the top index bit, so they exercise the full-width tag compare. The pair 8'h05 and 8'h8D covers a partner probe from the upper half of the index range down to the lower half.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_FAST = 2'b01,
    RSP_SLOW = 2'b10,
    RSP_MISS = 2'b11
  } rsp_status_e;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_ALT,
    CS_SWAP,
    CS_FILL
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useHeld;      // compare against the latched address
    logic capture;      // latch the incoming request address
    logic rspFromPrim;  // load response with first-slot line
    logic swapLines;    // exchange first and partner slots
    logic fillLine;     // write refill line, move displaced line
  } dp_strobe_t;

endpackage

// File: rtl/pa_datapath.sv
module pa_datapath
  import pa_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  dp_strobe_t        strb,
  input  logic [DATA_W-1:0] fillData,
  output logic              primHit,
  output logic              altHit,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] fillAddr
);

  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W + 1;
  localparam logic [IDX_W-1:0] FLIP = {1'b1, {(IDX_W-1){1'b0}}};

  logic [ADDR_W-1:0] heldAddr;
  logic [TAG_W-1:0]  tagQ   [SETS];
  logic [DATA_W-1:0] dataQ  [SETS];
  logic              validQ [SETS];

  logic [ADDR_W-1:0] curAddr;
  logic [IDX_W-1:0]  curIdx, curAlt, heldIdx, heldAlt;
  logic [TAG_W-1:0]  curTag, heldTag;
  logic [DATA_W-1:0] rspDataQ;

  assign curAddr = strb.useHeld ? heldAddr : reqAddr;
  assign curIdx  = curAddr[IDX_W-1:0];
  assign curAlt  = curIdx ^ FLIP;
  assign curTag  = curAddr[ADDR_W-1:IDX_W-1];
  assign heldIdx = heldAddr[IDX_W-1:0];
  assign heldAlt = heldIdx ^ FLIP;
  assign heldTag = heldAddr[ADDR_W-1:IDX_W-1];

  assign primHit = validQ[curIdx] && (tagQ[curIdx] == curTag);
  assign altHit  = validQ[curAlt] && (tagQ[curAlt] == curTag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) heldAddr <= '0;
    else if (strb.capture) heldAddr <= reqAddr;
  end

  generate
    for (genvar e = 0; e < SETS; e++) begin : g_slot
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(e);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          validQ[e] <= 1'b0;
          tagQ[e]   <= '0;
          dataQ[e]  <= '0;
        end else if (strb.swapLines) begin
          if (SLOT == heldIdx) begin
            validQ[e] <= validQ[heldAlt];
            tagQ[e]   <= tagQ[heldAlt];
            dataQ[e]  <= dataQ[heldAlt];
          end else if (SLOT == heldAlt) begin
            validQ[e] <= validQ[heldIdx];
            tagQ[e]   <= tagQ[heldIdx];
            dataQ[e]  <= dataQ[heldIdx];
          end
        end else if (strb.fillLine) begin
          if (SLOT == heldIdx) begin
            validQ[e] <= 1'b1;
            tagQ[e]   <= heldTag;
            dataQ[e]  <= fillData;
          end else if ((SLOT == heldAlt) && validQ[heldIdx]) begin
            validQ[e] <= 1'b1;
            tagQ[e]   <= tagQ[heldIdx];
            dataQ[e]  <= dataQ[heldIdx];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rspDataQ <= '0;
    else if (strb.capture && strb.rspFromPrim) rspDataQ <= dataQ[curIdx];
    else if (strb.swapLines) rspDataQ <= dataQ[heldAlt];
    else if (strb.fillLine) rspDataQ <= fillData;
  end

  assign rspData  = rspDataQ;
  assign fillAddr = heldAddr;

  // a line lives in at most one of its two candidate slots
  p_single_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(primHit && altHit));

  // after a swap, the requested line sits in its first slot
  p_swap_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.swapLines |=> validQ[heldIdx] && (tagQ[heldIdx] == heldTag));

  // the refilled line lands in the first slot with the returned data
  p_fill_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fillLine |=> validQ[heldIdx] && (tagQ[heldIdx] == heldTag)
                      && (dataQ[heldIdx] == $past(fillData)));

endmodule

// File: rtl/pa_control.sv
module pa_control
  import pa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       primHit,
  input  logic       altHit,
  input  logic       fillValid,
  output dp_strobe_t strb,
  output logic       busy,
  output logic       fillReq,
  output logic       rspValid,
  output logic [1:0] rspStatus
);

  ctrl_state_e stateQ, stateD;
  logic        rspValidQ, rspValidD;
  rsp_status_e rspStatusQ, rspStatusD;

  always_comb begin
    stateD     = stateQ;
    strb       = '0;
    rspValidD  = 1'b0;
    rspStatusD = RSP_NONE;
    case (stateQ)
      CS_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          if (primHit) begin
            strb.rspFromPrim = 1'b1;
            rspValidD        = 1'b1;
            rspStatusD       = RSP_FAST;
          end else begin
            stateD = CS_ALT;
          end
        end
      end
      CS_ALT: begin
        strb.useHeld = 1'b1;
        stateD       = altHit ? CS_SWAP : CS_FILL;
      end
      CS_SWAP: begin
        strb.useHeld   = 1'b1;
        strb.swapLines = 1'b1;
        rspValidD      = 1'b1;
        rspStatusD     = RSP_SLOW;
        stateD         = CS_IDLE;
      end
      CS_FILL: begin
        strb.useHeld = 1'b1;
        if (fillValid) begin
          strb.fillLine = 1'b1;
          rspValidD     = 1'b1;
          rspStatusD    = RSP_MISS;
          stateD        = CS_IDLE;
        end
      end
      default: stateD = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ     <= CS_IDLE;
      rspValidQ  <= 1'b0;
      rspStatusQ <= RSP_NONE;
    end else begin
      stateQ     <= stateD;
      rspValidQ  <= rspValidD;
      rspStatusQ <= rspStatusD;
    end
  end

  assign busy      = (stateQ != CS_IDLE);
  assign fillReq   = (stateQ == CS_FILL);
  assign rspValid  = rspValidQ;
  assign rspStatus = rspStatusQ;

  // swap cycle only ever follows the partner probe
  p_swap_after_probe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == CS_SWAP) |-> ($past(stateQ) == CS_ALT));

  // refill request holds until the line returns
  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fillReq && !fillValid) |=> fillReq);

  // a response always lands with the controller free again
  p_rsp_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> !busy);

  // a response always carries a real outcome code
  p_rsp_coded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (rspStatus != 2'b00));

endmodule

// File: rtl/pa_lookup_top.sv
module pa_lookup_top
  import pa_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspStatus,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData
);

  dp_strobe_t strb;
  logic       primHit, altHit;

  pa_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .primHit   (primHit),
    .altHit    (altHit),
    .fillValid (fillValid),
    .strb      (strb),
    .busy      (busy),
    .fillReq   (fillReq),
    .rspValid  (rspValid),
    .rspStatus (rspStatus)
  );

  pa_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqAddr  (reqAddr),
    .strb     (strb),
    .fillData (fillData),
    .primHit  (primHit),
    .altHit   (altHit),
    .rspData  (rspData),
    .fillAddr (fillAddr)
  );

endmodule

// File: tb/sim_pa_lookup_top.sv
module sim_pa_lookup_top;

  localparam int AW = 8;
  localparam int IW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          busy, rspValid, fillReq;
  logic [DW-1:0] rspData;
  logic [1:0]    rspStatus;
  logic [AW-1:0] fillAddr;
  logic          fillValid = 1'b0;
  logic [DW-1:0] fillData = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pa_lookup_top #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy), .rspValid(rspValid), .rspData(rspData), .rspStatus(rspStatus),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid), .fillData(fillData)
  );

  function automatic logic [DW-1:0] lineOf(input logic [AW-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one access; fillDelay = cycles the next level waits; intrude = drive a
  // request while busy (R9)
  task automatic access(input logic [AW-1:0] a, input logic [1:0] expSt,
                        input int fillDelay, input bit intrude);
    int lat = 1;
    int fl  = 0;
    int wc  = 0;
    string rq;
    int expLat;
    rq = (expSt == 2'b01) ? "R1" : (expSt == 2'b10) ? "R3" : "R6";
    expLat = (expSt == 2'b11) ? 3 + fillDelay : (expSt == 2'b10) ? 3 : 1;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
    if (expSt != 2'b01) check(busy == 1'b1, "R9", "busy during probe", busy, 1);
    while (!rspValid && lat < 40) begin
      fillValid = 1'b0;
      reqValid  = 1'b0;
      if (intrude && lat == 1) begin
        reqValid = 1'b1;
        reqAddr  = a ^ 8'h10;
      end
      if (fillReq) begin
        if (fl == 0) fl = lat;
        check(fillAddr == a, "R5", "fillAddr", fillAddr, a);
        if (wc == fillDelay) begin
          fillValid = 1'b1;
          fillData  = lineOf(a);
        end
        wc++;
      end
      @(negedge clk);
      lat++;
    end
    fillValid = 1'b0;
    reqValid  = 1'b0;
    check(rspValid == 1'b1, rq, "response seen", rspValid, 1);
    check(rspStatus == expSt, rq, "status", rspStatus, expSt);
    check(rspData == lineOf(a), rq, "data", rspData, lineOf(a));
    check(lat == expLat, rq, "latency", lat, expLat);
    if (expSt == 2'b11) check(fl == 2, "R5", "fillReq cycle", fl, 2);
    else check(fl == 0, "R2", "no refill on hit", fl, 0);
  endtask

  // {address, expected status}; 01 fast, 10 slow, 11 miss
  localparam logic [9:0] VEC [16] = '{
    {8'h13, 2'b11},  // cold miss into slot 3 (R6), partner 11 empty (R7)
    {8'h13, 2'b01},  // fast hit
    {8'h23, 2'b11},  // both probes miss, 13 moves to slot 11 (R7)
    {8'h13, 2'b10},  // found in partner slot 11 (R2), swap
    {8'h13, 2'b01},  // fast after swap (R4)
    {8'h23, 2'b10},  // swap back
    {8'h1B, 2'b11},  // home 11 holds 13: no false hit (R8); 13 moves to slot 3
    {8'h13, 2'b01},  // displaced line now fast in slot 3 (R7)
    {8'h23, 2'b11},  // 23 was evicted; 13 moves to slot 11
    {8'h1B, 2'b11},  // slot 11 holds 13, top-bit-only difference (R8)
    {8'h1B, 2'b01},
    {8'h13, 2'b01},
    {8'h05, 2'b11},  // slot 5, partner 13 empty
    {8'h8D, 2'b11},  // index 13 probes partner 5 (R2); slot 13 was empty
    {8'h05, 2'b01},  // slot 5 kept its line (R7)
    {8'h8D, 2'b01}
  };

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 1'b0, "R10", "busy in reset", busy, 0);
    check(rspValid == 1'b0, "R10", "rspValid in reset", rspValid, 0);
    check(fillReq == 1'b0, "R10", "fillReq in reset", fillReq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && rspValid == 1'b0 && fillReq == 1'b0, "R10",
          "idle after reset", {busy, rspValid, fillReq}, 0);

    for (int i = 0; i < 16; i++) begin
      access(VEC[i][9:2], VEC[i][1:0], 0, 1'b0);
    end

    // R5 slow next level, R9 request during refill ignored
    access(8'h40, 2'b11, 3, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rspValid == 1'b0 && fillReq == 1'b0, "R9", "no response to ignored request",
            {rspValid, fillReq}, 0);
    end
    access(8'h40, 2'b01, 0, 1'b0);
    access(8'h50, 2'b11, 1, 1'b0);  // ignored request left nothing behind (R9)

    // R10 reset empties the store
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(8'h13, 2'b11, 0, 1'b0);  // R10 previously cached line now misses

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule